// File: doc/BRIEF.md
# PCI Host Bridge Control Register Block

This block is the processor-facing control register file of a PCI host bridge. A 32-bit register bus reaches a window of 0x224 bytes. The window holds the bridge's own 64-word configuration header, a configuration address register, a memory base register and an I/O base register. The memory and I/O base registers keep only selected bits. The I/O base also drives an offset output that a downstream address decoder uses to place the I/O window.

A data port at offset 0x220 turns each register access into one configuration cycle toward the bus side. The target of that cycle is the address held in the configuration address register. The bridge also routes four device interrupt lines onto four interrupt outputs, using a slot number supplied for each device.

Register bus rules: the master holds `bus_rd` or `bus_wr`, together with the address and write data, until it sees `bus_ready` high. The access completes on that clock edge, and the master drops the strobe before the following edge.

Configuration request rules: `cfgq_valid` rises together with the direction, address and write data of the request. All of these stay constant until the bus side raises `cfgq_ready` on a clock edge. Read data on `cfgq_rdata` is sampled on that same edge. The bus side may hold `cfgq_ready` low for as long as it needs; this is its back-pressure.

Top module: `pcib_regs`

## Requirements
- R1: After reset, configuration word 0 reads `{DEVICE_ID, VENDOR_ID}` and word 1 reads 0x0290_0080. That value is the command word with bit 7 set, and the status word with bit 4, bit 7 and bits 10:9 = 01 set. All other configuration words, the address register and both base registers read zero.
- R2: Offsets 0x000–0x0FC map to 64 configuration words, one word per 4 bytes. Each word is fully 32-bit readable and writable.
- R3: Offset 0x1C0 holds the configuration address and is fully 32-bit readable and writable.
- R4: A write to offset 0x1C4 (memory base) keeps bits 31:24 and bit 0. All other bits read back as zero.
- R5: A write to offset 0x1C8 (I/O base) keeps bits 31:18 and bit 0. `io_win_offset` equals bits 31:18 of that register with bits 17:0 zero, is zero after reset, and changes only on a write to 0x1C8.
- R6: A write to 0x220 raises `cfgq_valid` with `cfgq_write`=1, `cfgq_addr` equal to the configuration address register and `cfgq_wdata` equal to the written data. These stay stable until `cfgq_ready`, and `bus_ready` stays low until then.
- R7: A read of 0x220 issues a request with `cfgq_write`=0. `bus_ready` rises in the cycle after the handshake, with `bus_rdata` equal to `cfgq_rdata` as sampled at the handshake.
- R8: A read of any other offset, or of an address with bits 1:0 non-zero, returns zero. A write to such an address changes no register.
- R9: `irq_out[k]` is the OR of every `dev_irq[i]` whose slot field `irq_slot[2i+1:2i]` equals k.
- R10: Every access outside the data port completes in the same cycle it is presented: `bus_ready` is high combinationally, and the write takes effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte offset within the register window |
| bus_rd | input | 1 | Read strobe, held until ready |
| bus_wr | input | 1 | Write strobe, held until ready |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when ready |
| bus_ready | output | 1 | Access completes this cycle |
| cfgq_valid | output | 1 | Configuration cycle request pending |
| cfgq_write | output | 1 | 1 = configuration write, 0 = read |
| cfgq_addr | output | 32 | Configuration cycle address |
| cfgq_wdata | output | 32 | Configuration write data |
| cfgq_ready | input | 1 | Bus side accepts and completes the request |
| cfgq_rdata | input | 32 | Configuration read data, sampled with ready |
| io_win_offset | output | 32 | I/O window offset from the I/O base |
| dev_irq | input | 4 | Device interrupt lines |
| irq_slot | input | 8 | 2-bit slot number per device |
| irq_out | output | 4 | Routed interrupt outputs |

## Verification
The bench targets the base-register masks with all-ones and alternating patterns. A design with a wrong mask would leak bits 23:1 or 17:1, or would move the I/O window offset by a stray low bit. The data port is exercised with response delays of zero and several cycles. A block that released `bus_ready` early, or sampled the read data before the handshake, would return stale data or finish in the wrong number of cycles. A design that let the request address or data move during back-pressure would mismatch in the request scoreboard. Misaligned addresses and the gaps between registers are probed: a decoder that ignored bits 1:0, or aliased gap addresses onto nearby registers, would return non-zero data or corrupt a neighbour. Interrupt routing is checked with several devices sharing one slot, where a decoder that kept only the last match would drop a line.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
  localparam int unsigned WIN_AW = 10;
  localparam logic [WIN_AW-1:0] OFS_CADDR  = 10'h1C0;
  localparam logic [WIN_AW-1:0] OFS_MBASE  = 10'h1C4;
  localparam logic [WIN_AW-1:0] OFS_IOBASE = 10'h1C8;
  localparam logic [WIN_AW-1:0] OFS_DPORT  = 10'h220;
  localparam logic [31:0] MBASE_KEEP  = 32'hFF00_0001;
  localparam logic [31:0] IOBASE_KEEP = 32'hFFFC_0001;
  localparam logic [31:0] IOWIN_KEEP  = 32'hFFFC_0000;
  localparam logic [15:0] CMD_INIT  = 16'h0080;
  localparam logic [15:0] STAT_INIT = 16'h0290;

  typedef enum logic [1:0] {DP_IDLE, DP_REQ, DP_DONE} dport_state_t;

  typedef struct packed {
    logic cfg;
    logic caddr;
    logic mbase;
    logic iobase;
    logic dport;
  } reg_sel_t;
endpackage

// File: rtl/pcib_cfg_space.sv
module pcib_cfg_space #(
  parameter int unsigned WORDS     = 64,
  parameter logic [15:0] VENDOR_ID = 16'h1054,
  parameter logic [15:0] DEVICE_ID = 16'h350E,
  localparam int unsigned IDX_W    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  import pcib_pkg::*;

  logic [31:0] word_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [31:0] INIT = (w == 0) ? {DEVICE_ID, VENDOR_ID} :
                                   (w == 1) ? {STAT_INIT, CMD_INIT} : 32'h0;
    always_ff @(posedge clk) begin
      if (!rst_n)                               word_q[w] <= INIT;
      else if (we && idx == IDX_W'(w))          word_q[w] <= wdata;
    end
  end

  assign rdata = word_q[idx];

  // R2: a written word holds its value on the next cycle
  a_r2_word_written: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (word_q[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/pcib_dport.sv
module pcib_dport (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        access,
  input  logic        is_write,
  input  logic [31:0] target,
  input  logic [31:0] wdata,
  output logic        done,
  output logic [31:0] rdata,
  output logic        req_valid,
  output logic        req_write,
  output logic [31:0] req_addr,
  output logic [31:0] req_wdata,
  input  logic        req_ready,
  input  logic [31:0] rsp_data
);
  import pcib_pkg::*;

  dport_state_t state_q;
  logic [31:0]  addr_q, wdat_q, rdat_q;
  logic         wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= DP_IDLE;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        DP_IDLE: if (access) begin
          state_q <= DP_REQ;
          addr_q  <= target;
          wdat_q  <= wdata;
          wr_q    <= is_write;
        end
        DP_REQ: if (req_ready) begin
          state_q <= DP_DONE;
          rdat_q  <= wr_q ? 32'h0 : rsp_data;
        end
        DP_DONE: state_q <= DP_IDLE;
        default: state_q <= DP_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == DP_REQ);
  assign req_write = wr_q;
  assign req_addr  = addr_q;
  assign req_wdata = wdat_q;
  assign done      = (state_q == DP_DONE);
  assign rdata     = rdat_q;

  // R6: request fields held steady under back-pressure
  a_r6_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_wdata) && $stable(req_write)));
  // R7: completion only follows a handshake
  a_r7_done_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid && req_ready));
endmodule

// File: rtl/pcib_irq_route.sv
module pcib_irq_route #(
  parameter int unsigned LINES  = 4,
  localparam int unsigned SLOT_W = $clog2(LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LINES-1:0]        dev_irq,
  input  logic [LINES*SLOT_W-1:0] slot,
  output logic [LINES-1:0]        irq_out
);
  for (genvar k = 0; k < LINES; k++) begin : g_out
    always_comb begin
      irq_out[k] = 1'b0;
      for (int i = 0; i < LINES; i++)
        if (slot[i*SLOT_W +: SLOT_W] == SLOT_W'(k))
          irq_out[k] = irq_out[k] | dev_irq[i];
    end
  end

  // R9: no output asserted without some device interrupt
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq == '0) |-> (irq_out == '0));
  // R9: number of active outputs never exceeds active inputs
  a_r9_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(dev_irq));
endmodule

// File: rtl/pcib_regs.sv
module pcib_regs #(
  parameter int unsigned CFG_WORDS = 64,
  parameter int unsigned IRQ_LINES = 4,
  parameter logic [15:0] VENDOR_ID = 16'h1054,
  parameter logic [15:0] DEVICE_ID = 16'h350E,
  localparam int unsigned IDX_W    = $clog2(CFG_WORDS),
  localparam int unsigned SLOT_W   = $clog2(IRQ_LINES),
  localparam int unsigned CFG_BYTES = CFG_WORDS * 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [9:0]                  bus_addr,
  input  logic                        bus_rd,
  input  logic                        bus_wr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_ready,
  output logic                        cfgq_valid,
  output logic                        cfgq_write,
  output logic [31:0]                 cfgq_addr,
  output logic [31:0]                 cfgq_wdata,
  input  logic                        cfgq_ready,
  input  logic [31:0]                 cfgq_rdata,
  output logic [31:0]                 io_win_offset,
  input  logic [IRQ_LINES-1:0]        dev_irq,
  input  logic [IRQ_LINES*SLOT_W-1:0] irq_slot,
  output logic [IRQ_LINES-1:0]        irq_out
);
  import pcib_pkg::*;

  reg_sel_t    sel;
  logic        aligned, any_sel, acc;
  logic [31:0] caddr_q, mbase_q, iobase_q;
  logic [31:0] cfg_rdata, dp_rdata;
  logic        dp_done;

  assign acc     = bus_rd | bus_wr;
  assign aligned = (bus_addr[1:0] == 2'b00);
  always_comb begin
    sel        = '0;
    sel.cfg    = aligned && ({22'h0, bus_addr} < CFG_BYTES);
    sel.caddr  = (bus_addr == OFS_CADDR);
    sel.mbase  = (bus_addr == OFS_MBASE);
    sel.iobase = (bus_addr == OFS_IOBASE);
    sel.dport  = (bus_addr == OFS_DPORT);
  end
  assign any_sel = |sel;

  pcib_cfg_space #(
    .WORDS(CFG_WORDS), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n),
    .we(bus_wr && sel.cfg),
    .idx(bus_addr[IDX_W+1:2]),
    .wdata(bus_wdata),
    .rdata(cfg_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      caddr_q  <= '0;
      mbase_q  <= '0;
      iobase_q <= '0;
    end else if (bus_wr) begin
      if (sel.caddr)  caddr_q  <= bus_wdata;
      if (sel.mbase)  mbase_q  <= bus_wdata & MBASE_KEEP;
      if (sel.iobase) iobase_q <= bus_wdata & IOBASE_KEEP;
    end
  end

  assign io_win_offset = iobase_q & IOWIN_KEEP;

  pcib_dport i_dport (
    .clk(clk), .rst_n(rst_n),
    .access(acc && sel.dport),
    .is_write(bus_wr),
    .target(caddr_q),
    .wdata(bus_wdata),
    .done(dp_done),
    .rdata(dp_rdata),
    .req_valid(cfgq_valid),
    .req_write(cfgq_write),
    .req_addr(cfgq_addr),
    .req_wdata(cfgq_wdata),
    .req_ready(cfgq_ready),
    .rsp_data(cfgq_rdata)
  );

  assign bus_ready = sel.dport ? dp_done : acc;

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_rd) begin
      unique case (1'b1)
        sel.cfg:    bus_rdata = cfg_rdata;
        sel.caddr:  bus_rdata = caddr_q;
        sel.mbase:  bus_rdata = mbase_q;
        sel.iobase: bus_rdata = iobase_q;
        sel.dport:  bus_rdata = dp_rdata;
        default:    bus_rdata = 32'h0;
      endcase
    end
  end

  pcib_irq_route #(.LINES(IRQ_LINES)) i_irq (
    .clk(clk), .rst_n(rst_n),
    .dev_irq(dev_irq), .slot(irq_slot), .irq_out(irq_out)
  );

  // R4: memory base keeps only its allowed bits
  a_r4_mbase_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel.mbase) |=> (mbase_q == ($past(bus_wdata) & 32'hFF00_0001)));
  // R5: window offset moves only on an I/O base write
  a_r5_iowin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel.iobase) |=> $stable(io_win_offset));
  // R8: unmapped reads return zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !any_sel) |-> (bus_rdata == 32'h0));
  // R10: register accesses outside the data port take no wait cycle
  a_r10_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !sel.dport) |-> bus_ready);
  // R6: no request launched without a data-port access
  a_r6_req_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfgq_valid) |-> $past(acc && sel.dport));
endmodule

// File: tb/test_pcib_regs.sv
module test_pcib_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_ready;
  logic        cfgq_valid, cfgq_write;
  logic [31:0] cfgq_addr, cfgq_wdata;
  logic        cfgq_ready = 1'b0;
  logic [31:0] cfgq_rdata = '0;
  logic [31:0] io_win_offset;
  logic [3:0]  dev_irq = '0;
  logic [7:0]  irq_slot = '0;
  logic [3:0]  irq_out;

  always #2.5 clk = ~clk;

  pcib_regs #(.VENDOR_ID(16'hABCD), .DEVICE_ID(16'h1234)) i_pcib_regs (.*);

  int vectors = 0, miscompares = 0;
  int resp_delay = 0;
  bit finished = 0;
  logic [64:0] exp_q[$];   // {write, addr, wdata}

  function automatic logic [31:0] rsp_of(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [9:0] a, input logic [31:0] d,
                        output logic [31:0] q, output int waited);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = wr; bus_rd = !wr;
    waited = 0;
    #1;
    while (!bus_ready && waited < 100) begin
      @(negedge clk); #1; waited++;
    end
    q = bus_rdata;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] q; int w;
    access(1'b0, a, '0, q, w);
    chk(req, q, exp);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] q; int w;
    access(1'b1, a, d, q, w);
  endtask

  // Bus-side responder and request monitor (scoreboard)
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (cfgq_ready) begin
        cfgq_ready = 1'b0;
      end else if (cfgq_valid) begin
        if (cnt == resp_delay) begin
          cnt = 0;
          cfgq_rdata = rsp_of(cfgq_addr);
          cfgq_ready = 1'b1;
          if (exp_q.size() == 0) begin
            vectors++; miscompares++;
            $display("FAIL R6: actual unexpected request %h expected none", cfgq_addr);
          end else begin
            logic [64:0] e;
            e = exp_q.pop_front();
            chk(e[64] ? "R6 dir" : "R7 dir", {31'h0, cfgq_write}, {31'h0, e[64]});
            chk(e[64] ? "R6 addr" : "R7 addr", cfgq_addr, e[63:32]);
            if (e[64]) chk("R6 wdata", cfgq_wdata, e[31:0]);
          end
        end else cnt++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R6: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] q; int w;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd("R1 id", 10'h000, 32'h1234_ABCD);
    rd("R1 cmd/status", 10'h004, 32'h0290_0080);
    rd("R1 word2", 10'h008, 32'h0);
    rd("R1 caddr", 10'h1C0, 32'h0);
    rd("R1 mbase", 10'h1C4, 32'h0);
    rd("R1 iobase", 10'h1C8, 32'h0);
    chk("R5 reset offset", io_win_offset, 32'h0);

    // R2 configuration words, R10 zero wait
    wr(10'h010, 32'hDEAD_BEEF);
    wr(10'h0FC, 32'h0123_4567);
    wr(10'h000, 32'hFFFF_0000);
    rd("R2 word4", 10'h010, 32'hDEAD_BEEF);
    rd("R2 last word", 10'h0FC, 32'h0123_4567);
    rd("R2 word0", 10'h000, 32'hFFFF_0000);
    access(1'b0, 10'h010, '0, q, w);
    chk("R10 wait cycles", w, 0);

    // R3
    wr(10'h1C0, 32'h8000_1A2C);
    rd("R3 caddr", 10'h1C0, 32'h8000_1A2C);

    // R4 masks
    wr(10'h1C4, 32'hFFFF_FFFF);
    rd("R4 ones", 10'h1C4, 32'hFF00_0001);
    wr(10'h1C4, 32'h5AA5_5AA4);
    rd("R4 pattern", 10'h1C4, 32'h5A00_0000);

    // R5 masks and offset
    wr(10'h1C8, 32'hFFFF_FFFF);
    rd("R5 ones", 10'h1C8, 32'hFFFC_0001);
    chk("R5 offset ones", io_win_offset, 32'hFFFC_0000);
    wr(10'h1C8, 32'h1237_FFFE);
    rd("R5 pattern", 10'h1C8, 32'h1234_0000);
    chk("R5 offset pattern", io_win_offset, 32'h1234_0000);
    wr(10'h1C4, 32'h0);
    chk("R5 offset unaffected", io_win_offset, 32'h1234_0000);

    // R8 unmapped and misaligned
    rd("R8 gap", 10'h100, 32'h0);
    rd("R8 gap2", 10'h1CC, 32'h0);
    rd("R8 misaligned", 10'h1C2, 32'h0);
    wr(10'h1C2, 32'hFFFF_FFFF);
    wr(10'h011, 32'h0);
    wr(10'h1CC, 32'hFFFF_FFFF);
    wr(10'h200, 32'hFFFF_FFFF);
    rd("R8 caddr kept", 10'h1C0, 32'h8000_1A2C);
    rd("R8 word4 kept", 10'h010, 32'hDEAD_BEEF);
    rd("R8 iobase kept", 10'h1C8, 32'h1234_0000);

    // R6 data-port write, delays 0 and 4
    for (int d = 0; d <= 4; d += 4) begin
      resp_delay = d;
      exp_q.push_back({1'b1, 32'h8000_1A2C, 32'hC0DE_0000 + d});
      access(1'b1, 10'h220, 32'hC0DE_0000 + d, q, w);
      chk("R6 ready wait", w, 2 + d);
    end

    // R7 data-port read, delays 0 and 3, new target address
    wr(10'h1C0, 32'h8000_0810);
    for (int d = 0; d <= 3; d += 3) begin
      resp_delay = d;
      exp_q.push_back({1'b0, 32'h8000_0810, 32'h0});
      access(1'b0, 10'h220, '0, q, w);
      chk("R7 read data", q, rsp_of(32'h8000_0810));
      chk("R7 ready wait", w, 2 + d);
    end
    chk("R6 scoreboard drained", exp_q.size(), 0);

    // R9 interrupt routing
    @(negedge clk);
    irq_slot = {2'd3, 2'd2, 2'd1, 2'd0}; dev_irq = 4'b0101; #1;
    chk("R9 identity", {28'h0, irq_out}, 32'h5);
    @(negedge clk);
    irq_slot = {2'd0, 2'd0, 2'd3, 2'd1}; dev_irq = 4'b1100; #1;
    chk("R9 shared slot", {28'h0, irq_out}, 32'h1);
    @(negedge clk);
    dev_irq = 4'b0011; #1;
    chk("R9 swapped", {28'h0, irq_out}, 32'hA);
    @(negedge clk);
    dev_irq = 4'b1000; #1;
    chk("R9 shared one", {28'h0, irq_out}, 32'h1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule